// File: doc/BRIEF.md
# PCI Express Compliance Pattern Generator

This block produces the repeating compliance symbol stream for a PIPE-style transmit data path. The stream runs ahead of the 8b/10b encoder, so it is unencoded. On every parallel clock it drives a data word, one control-character flag per byte lane and one forced-disparity flag per byte lane. A parameter sets the channel width to one byte lane (8-bit) or two byte lanes (16-bit).

The pattern is K28.5, D21.5, K28.5, D10.2 (byte values 0xBC, 0xB5, 0xBC, 0x4A), repeated for as long as the enable input stays high. Each run starts from the first K28.5. Only the word that carries that first K28.5 raises the low forced-disparity bit. A downstream encoder can use this to pin the running disparity at the start of the pattern. When the enable is sampled low the outputs go to zero and the block waits for the next start.

A three-state controller sequences the run. ST_IDLE goes to ST_LEAD when the enable is sampled high (transition T_START). ST_LEAD goes to ST_STREAM on the next high sample (T_CONTINUE). ST_STREAM holds while the enable stays high (T_HOLD). Any state returns to ST_IDLE when the enable is sampled low or on reset (T_STOP). A phase counter tracks the word position inside the pattern period, and a lane mapper turns the phase into bytes and flags.

Top module: `cpg_compliance_gen`

## Requirements
- R1: While rst_n (active-low, synchronous) is sampled low, the next cycle shows tx_data, tx_kflag and tx_force_disp all zero, and the pattern restarts from its first symbol afterwards.
- R2: While en is sampled low, the following cycle shows all-zero data, control flags and forced-disparity flags.
- R3: With LANES=1, the cycle after en is first sampled high shows 0xBC. Each later cycle with en still high steps through 0xB5, 0xBC, 0x4A, 0xBC, and so on.
- R4: tx_kflag bit l is 1 exactly when byte lane l carries 0xBC (K28.5) during an active run, and 0 for data bytes. With LANES=2 the flag bus is 2'b01 on every active word.
- R5: tx_force_disp is 1 in bit 0 only on the first word of a run. On every later word of the run it is all zero, and bits above 0 are never set.
- R6: With LANES=2, an active run alternates between the words 0xB5BC and 0x4ABC, starting with 0xB5BC. The low byte is the K28.5.
- R7: After en is sampled low and then high again, the run restarts at the first word (0xBC or 0xB5BC) and the forced-disparity pulse occurs again.
- R8: A single low sample of en in the middle of a run gives exactly one all-zero cycle. The block never holds a partial phase across that cycle.
- R9: The pattern period is 4/LANES words. After a full period the first word's data returns, without the forced-disparity pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run request; sampled on each rising edge |
| tx_data | output | 8*LANES | Unencoded symbol word, lane 0 in the low byte |
| tx_kflag | output | LANES | Per-lane control-character flag |
| tx_force_disp | output | LANES | Per-lane forced-disparity flag |

## Verification
Two functions share one cycle here: the forced-disparity pulse and the pattern restart both land on the first word after a start. A start can also follow a one-cycle stop or a mid-run reset. The bench provokes this by dropping en for exactly one cycle in the middle of the pattern, and by pulsing rst_n during a run. The scoreboard model then expects the first K28.5 word with bit 0 of the forced-disparity flag set, not a continuation of the old phase, and judges both lane widths side by side on identical stimulus.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_STREAM = 2'd2
    } cpg_state_e;

    localparam logic [7:0] SYM_K28_5 = 8'hBC;
    localparam logic [7:0] SYM_D21_5 = 8'hB5;
    localparam logic [7:0] SYM_D10_2 = 8'h4A;

    // Slot positions in the four-symbol pattern: even slots hold the comma.
    function automatic logic [7:0] slot_byte(input logic [1:0] slot);
        logic [7:0] b;
        unique case (slot)
            2'd0:    b = SYM_K28_5;
            2'd1:    b = SYM_D21_5;
            2'd2:    b = SYM_K28_5;
            default: b = SYM_D10_2;
        endcase
        return b;
    endfunction

    function automatic logic slot_is_ctrl(input logic [1:0] slot);
        return ~slot[0];
    endfunction

endpackage

// File: rtl/cpg_ctrl_fsm.sv
module cpg_ctrl_fsm
    import cpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    output cpg_state_e state_q,
    output cpg_state_e state_d,
    output logic       active,
    output logic       lead
);

    always_comb begin
        state_d = ST_IDLE;
        if (en) begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_LEAD;    // T_START
                ST_LEAD:   state_d = ST_STREAM;  // T_CONTINUE
                ST_STREAM: state_d = ST_STREAM;  // T_HOLD
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;          // T_STOP when en low
    end

    always_comb begin
        active = 1'b0;
        lead   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LEAD:   begin active = 1'b1; lead = 1'b1; end
            ST_STREAM: active = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/cpg_phase_ctr.sv
module cpg_phase_ctr
    import cpg_pkg::*;
#(
    parameter int PERIOD = 4,
    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1
)(
    input  logic          clk,
    input  logic          rst_n,
    input  cpg_state_e    state_d,
    output logic [PW-1:0] phase_q
);

    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

    logic [PW-1:0] phase_d;

    always_comb begin
        phase_d = '0;
        if (state_d == ST_STREAM)
            phase_d = (phase_q == LAST) ? '0 : phase_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

endmodule

// File: rtl/cpg_lane_map.sv
module cpg_lane_map
    import cpg_pkg::*;
#(
    parameter int LANES = 1,
    parameter int PW    = 2
)(
    input  logic [PW-1:0]      phase,
    input  logic               active,
    input  logic               lead,
    output logic [8*LANES-1:0] data,
    output logic [LANES-1:0]   kflag,
    output logic [LANES-1:0]   fdisp
);

    localparam int WW = PW + 3;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [WW-1:0] pos;
        logic [1:0]    slot;

        always_comb begin
            pos  = WW'(phase) * WW'(LANES) + WW'(l);
            slot = pos[1:0];
        end

        assign data[8*l +: 8] = active ? slot_byte(slot) : 8'h00;
        assign kflag[l]       = active & slot_is_ctrl(slot);

        if (l == 0) begin : g_fd_low
            assign fdisp[l] = active & lead;
        end else begin : g_fd_hi
            assign fdisp[l] = 1'b0;
        end
    end

endmodule

// File: rtl/cpg_compliance_gen.sv
module cpg_compliance_gen
    import cpg_pkg::*;
#(
    parameter int LANES = 1,
    localparam int PERIOD = 4 / LANES,
    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    output logic [8*LANES-1:0] tx_data,
    output logic [LANES-1:0]   tx_kflag,
    output logic [LANES-1:0]   tx_force_disp
);

    cpg_state_e    state_q;
    cpg_state_e    state_d;
    logic          active;
    logic          lead;
    logic [PW-1:0] phase_q;

    cpg_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .state_q (state_q),
        .state_d (state_d),
        .active  (active),
        .lead    (lead)
    );

    cpg_phase_ctr #(.PERIOD(PERIOD)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .phase_q (phase_q)
    );

    cpg_lane_map #(.LANES(LANES), .PW(PW)) u_map (
        .phase  (phase_q),
        .active (active),
        .lead   (lead),
        .data   (tx_data),
        .kflag  (tx_kflag),
        .fdisp  (tx_force_disp)
    );

endmodule

// File: rtl/cpg_compliance_gen_chk.sv
module cpg_compliance_gen_chk #(
    parameter int LANES = 1
)(
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic [8*LANES-1:0] tx_data,
    input logic [LANES-1:0]   tx_kflag,
    input logic [LANES-1:0]   tx_force_disp
);

    logic live_q;
    logic live_qq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= 1'b0;
            live_qq <= 1'b0;
        end else begin
            live_q  <= en;
            live_qq <= live_q;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !live_q |-> (tx_data == '0 && tx_kflag == '0 && tx_force_disp == '0)); // R2

    AST_FD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !live_qq) |-> (tx_force_disp == LANES'(1))); // R5

    AST_FD_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        live_qq |-> (tx_force_disp == '0)); // R5

    AST_START_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !live_qq) |-> (tx_data[7:0] == 8'hBC)); // R7

    AST_WORD_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && live_qq) |-> (tx_data != $past(tx_data))); // R3

    for (genvar l = 0; l < LANES; l++) begin : g_k
        AST_KFLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            live_q |-> (tx_kflag[l] == (tx_data[8*l +: 8] == 8'hBC))); // R4
    end

endmodule

bind cpg_compliance_gen cpg_compliance_gen_chk #(.LANES(LANES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .tx_data       (tx_data),
    .tx_kflag      (tx_kflag),
    .tx_force_disp (tx_force_disp)
);

// File: tb/sim_cpg_compliance_gen.sv
module sim_cpg_compliance_gen;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0]  d1;
        logic        k1;
        logic        f1;
        logic [15:0] d2;
        logic [1:0]  k2;
        logic [1:0]  f2;
        string       tz;   // tag when zero expected
        string       td1;
        string       td2;
        string       tf;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [7:0]  d1;
    logic [0:0]  k1, f1;
    logic [15:0] d2;
    logic [1:0]  k2, f2;

    int   errors = 0;
    int   checks = 0;
    exp_t q[$];

    bit   m_run = 0;
    bit   m_ever = 0;
    int   m_idx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpg_compliance_gen #(.LANES(1)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en),
        .tx_data(d1), .tx_kflag(k1), .tx_force_disp(f1)
    );

    cpg_compliance_gen #(.LANES(2)) u1 (
        .clk(clk), .rst_n(rst_n), .en(en),
        .tx_data(d2), .tx_kflag(k2), .tx_force_disp(f2)
    );

    function automatic logic [7:0] sym(input int s);
        case (s % 4)
            0, 2:    return 8'hBC;
            1:       return 8'hB5;
            default: return 8'h4A;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and predicts the next output.
    task automatic drive(input bit r, input bit e);
        exp_t x;
        bit first;
        @(negedge clk);
        rst_n = r;
        en    = e;
        x.d1 = '0; x.k1 = 0; x.f1 = 0; x.d2 = '0; x.k2 = '0; x.f2 = '0;
        x.tz = ""; x.td1 = "R3"; x.td2 = "R6"; x.tf = "R5";
        if (!r || !e) begin
            x.tz  = !r ? "R1" : (m_run ? "R8" : "R2");
            m_run = 0;
            m_idx = 0;
        end else begin
            first = !m_run;
            if (first) begin
                m_idx = 0;
                if (m_ever) begin x.td1 = "R7"; x.td2 = "R7"; x.tf = "R7"; end
            end else begin
                m_idx = m_idx + 1;
                if (m_idx % 4 == 0) x.td1 = "R9";
                if (m_idx % 2 == 0) x.td2 = "R9";
            end
            m_run  = 1;
            m_ever = 1;
            x.d1 = sym(m_idx);
            x.k1 = (m_idx % 2 == 0);
            x.f1 = first;
            x.d2 = {sym(2*m_idx + 1), sym(2*m_idx)};
            x.k2 = 2'b01;
            x.f2 = first ? 2'b01 : 2'b00;
        end
        q.push_back(x);
    endtask

    // Monitor: compares a quarter period after each rising edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            chk(x.tz != "" ? x.tz : x.td1, {8'h00, d1}, {8'h00, x.d1});
            chk(x.tz != "" ? x.tz : x.td2, d2, x.d2);
            chk(x.tz != "" ? x.tz : "R4", {15'h0, k1}, {15'h0, x.k1});
            chk(x.tz != "" ? x.tz : "R4", {14'h0, k2}, {14'h0, x.k2});
            chk(x.tz != "" ? x.tz : x.tf, {15'h0, f1}, {15'h0, x.f1});
            chk(x.tz != "" ? x.tz : x.tf, {14'h0, f2}, {14'h0, x.f2});
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 3; i++) drive(0, 1);        // R1 reset with en high
        for (int i = 0; i < 3; i++) drive(1, 0);        // R2 idle
        for (int i = 0; i < 11; i++) drive(1, 1);       // R3 R6 R9 long run
        for (int i = 0; i < 3; i++) drive(1, 0);
        for (int i = 0; i < 6; i++) drive(1, 1);        // R7 restart
        drive(1, 0);                                    // R8 single stop
        for (int i = 0; i < 5; i++) drive(1, 1);
        drive(0, 1);                                    // R1 reset mid-run
        for (int i = 0; i < 6; i++) drive(1, 1);
        for (int i = 0; i < 2; i++) drive(1, 0);
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule